// File: doc/BRIEF.md
# Data-Access Protection Check Unit

This unit sits next to the load/store stage of a processor pipeline. For each data access it decides whether a data-storage fault must be raised, using four inputs: the class of the operation, the privilege and translation bits of the current machine state word, the page attributes delivered by the translation lookup, and a real-mode store-trap map. Three separate causes are evaluated. The first blocks every access to a no-access zone. The second blocks writes to read-only pages unless the zone overrides the protection. The third traps stores to regions marked with the user-defined U0 attribute.

When a qualified access faults, the unit performs the interrupt entry on the next clock edge. It saves the effective address and the old machine state word into two save/restore registers. It clears the translation and user-mode bits of the state word, raises a one-cycle exception flag and forms the vector address. Software has no way to mask this fault. The surrounding pipeline reads the registered outputs and redirects fetch.

Top module: `access_fault_unit`

## Requirements
- R1: The no-access cause (cause bit 0) fires when the zone field is 0, user mode is set (machine-state bit 14 = 1) and translation is enabled (machine-state bit 4 = 1). The access class must be one of load (1), store (2), flush (3), clean (4), zero-line (5) or instruction-cache invalidate (6). Class code 0 is a non-memory slot, and class codes 7 and 8 are data-cache invalidate and set invalidate.
- R2: In user mode with translation on, the read-only cause (bit 1) fires on store or zero-line when the page write-enable is 0. Zone value 3 suppresses it.
- R3: In privileged mode with translation on, the read-only cause fires on store, zero-line, data-cache invalidate or set invalidate when the page write-enable is 0. Zone values 2 and 3 suppress it.
- R4: Neither the no-access cause nor the read-only cause fires while translation is off.
- R5: With the trap enable set, the U0 cause (bit 2) fires on the same per-mode store classes as R2/R3. With translation on, the U0 attribute is the page's U0 bit. With translation off, it is bit N of the region map, where N is the top 5 address bits, so bit 0 covers the lowest 128 MB.
- R6: With the trap enable clear, the U0 cause never fires.
- R7: On a faulting valid access, exc_taken is high for exactly the following cycle. In that same update, srr0 takes the effective address and srr1 takes the incoming machine state word.
- R8: msr_out takes the incoming machine state word with bits 4 and 14 cleared.
- R9: exc_vector takes the vector prefix in its upper 16 bits and 0x0300 in its lower 16 bits.
- R10: When several causes apply together, one exception is raised and exc_cause shows every active cause.
- R11: With acc_valid low, or on a valid access with no cause, exc_taken is low and srr0, srr1, msr_out, exc_vector and exc_cause keep their values.
- R12: After reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_class | input | 4 | Operation class code |
| acc_ea | input | 32 | Effective address of the instruction |
| msr_in | input | 32 | Current machine state word |
| zone | input | 2 | Zone protection field for the access |
| tlb_wr_en | input | 1 | Page write-enable from translation |
| tlb_u0 | input | 1 | Page U0 attribute from translation |
| u0_region_map | input | 32 | Real-mode U0 attribute, one bit per region |
| u0_trap_en | input | 1 | Enables the U0 store trap |
| vec_prefix | input | 16 | Upper half of the vector address |
| exc_taken | output | 1 | Exception entry pulse |
| exc_cause | output | 3 | Causes of the last fault |
| exc_vector | output | 32 | Handler address |
| srr0 | output | 32 | Saved effective address |
| srr1 | output | 32 | Saved machine state word |
| msr_out | output | 32 | Machine state word after entry |

## Verification
The bench builds the unit with its default parameters: 32-bit address and state words, 32 U0 regions, and state-word bit positions 4 and 14. With these values each region bit covers 128 MB, so the corner addresses of region 0 and region 31 can be driven directly. The same values allow each zone encoding to be tried in both privilege modes. A behavioural model predicts every output on every clock. Directed cases are followed by randomized accesses that mix causes, including cycles with acc_valid low.

// File: rtl/afu_pkg.sv
package afu_pkg;

    typedef enum logic [3:0] {
        CLS_NONE       = 4'd0,
        CLS_LOAD       = 4'd1,
        CLS_STORE      = 4'd2,
        CLS_FLUSH      = 4'd3,
        CLS_CLEAN      = 4'd4,
        CLS_ZERO_LINE  = 4'd5,
        CLS_ICACHE_INV = 4'd6,
        CLS_DCACHE_INV = 4'd7,
        CLS_SET_INV    = 4'd8
    } acc_class_e;

    localparam int CAUSE_W      = 3;
    localparam int CAUSE_NOACC  = 0;
    localparam int CAUSE_RDONLY = 1;
    localparam int CAUSE_U0     = 2;

    localparam logic [1:0] ZONE_NOACC = 2'b00;
    localparam logic [1:0] ZONE_FULL  = 2'b11;

endpackage

// File: rtl/afu_class_decode.sv
module afu_class_decode
    import afu_pkg::*;
(
    input  logic [3:0] cls_i,
    input  logic       user_i,
    output logic       zone_elig_o,
    output logic       store_like_o
);
    acc_class_e cls;
    logic       user_store;
    logic       priv_store;

    always_comb begin
        cls = acc_class_e'(cls_i);
        zone_elig_o = 1'b0;
        user_store  = 1'b0;
        priv_store  = 1'b0;
        case (cls)
            CLS_LOAD, CLS_FLUSH, CLS_CLEAN, CLS_ICACHE_INV: begin
                zone_elig_o = 1'b1;
            end
            CLS_STORE, CLS_ZERO_LINE: begin
                zone_elig_o = 1'b1;
                user_store  = 1'b1;
                priv_store  = 1'b1;
            end
            CLS_DCACHE_INV, CLS_SET_INV: begin
                priv_store  = 1'b1;
            end
            default: begin
                zone_elig_o = 1'b0;
            end
        endcase
        store_like_o = user_i ? user_store : priv_store;
    end
endmodule

// File: rtl/afu_u0_source.sv
module afu_u0_source #(
    parameter int ADDR_W  = 32,
    parameter int REGIONS = 32
) (
    input  logic [ADDR_W-1:0]  ea_i,
    input  logic               xlate_i,
    input  logic               tlb_u0_i,
    input  logic [REGIONS-1:0] region_map_i,
    output logic               u0_attr_o
);
    localparam int IDX_W = $clog2(REGIONS);

    logic [IDX_W-1:0] region_idx;

    always_comb begin
        region_idx = ea_i[ADDR_W-1 -: IDX_W];
        u0_attr_o  = xlate_i ? tlb_u0_i : region_map_i[region_idx];
    end
endmodule

// File: rtl/afu_cause_eval.sv
module afu_cause_eval
    import afu_pkg::*;
(
    input  logic               user_i,
    input  logic               xlate_i,
    input  logic [1:0]         zone_i,
    input  logic               wr_en_i,
    input  logic               u0_attr_i,
    input  logic               u0_trap_en_i,
    input  logic               zone_elig_i,
    input  logic               store_like_i,
    output logic [CAUSE_W-1:0] cause_o
);
    logic ro_override;

    always_comb begin
        ro_override = user_i ? (zone_i == ZONE_FULL) : zone_i[1];
        cause_o = '0;
        cause_o[CAUSE_NOACC]  = user_i && xlate_i && (zone_i == ZONE_NOACC)
                                && zone_elig_i;
        cause_o[CAUSE_RDONLY] = xlate_i && !wr_en_i && store_like_i
                                && !ro_override;
        cause_o[CAUSE_U0]     = u0_trap_en_i && u0_attr_i && store_like_i;
    end
endmodule

// File: rtl/access_fault_unit.sv
module access_fault_unit
    import afu_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          MSR_W      = 32,
    parameter int          U0_REGIONS = 32,
    parameter int          PREFIX_W   = 16,
    parameter int          MSR_XL_BIT = 4,
    parameter int          MSR_US_BIT = 14,
    parameter logic [15:0] VEC_OFFSET = 16'h0300
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc_valid,
    input  logic [3:0]             acc_class,
    input  logic [ADDR_W-1:0]      acc_ea,
    input  logic [MSR_W-1:0]       msr_in,
    input  logic [1:0]             zone,
    input  logic                   tlb_wr_en,
    input  logic                   tlb_u0,
    input  logic [U0_REGIONS-1:0]  u0_region_map,
    input  logic                   u0_trap_en,
    input  logic [PREFIX_W-1:0]    vec_prefix,
    output logic                   exc_taken,
    output logic [CAUSE_W-1:0]     exc_cause,
    output logic [PREFIX_W+15:0]   exc_vector,
    output logic [ADDR_W-1:0]      srr0,
    output logic [MSR_W-1:0]       srr1,
    output logic [MSR_W-1:0]       msr_out
);
    localparam int VEC_W = PREFIX_W + 16;

    typedef struct packed {
        logic               exc;
        logic [CAUSE_W-1:0] cause;
        logic [VEC_W-1:0]   vec;
        logic [ADDR_W-1:0]  srr0;
        logic [MSR_W-1:0]   srr1;
        logic [MSR_W-1:0]   msr;
    } state_t;

    state_t state_d, state_q;

    logic               user_w;
    logic               xlate_w;
    logic               zone_elig_w;
    logic               store_like_w;
    logic               u0_attr_w;
    logic [CAUSE_W-1:0] cause_w;
    logic               fault_w;

    assign user_w  = msr_in[MSR_US_BIT];
    assign xlate_w = msr_in[MSR_XL_BIT];

    afu_class_decode u_decode (
        .cls_i        (acc_class),
        .user_i       (user_w),
        .zone_elig_o  (zone_elig_w),
        .store_like_o (store_like_w)
    );

    afu_u0_source #(
        .ADDR_W  (ADDR_W),
        .REGIONS (U0_REGIONS)
    ) u_u0 (
        .ea_i         (acc_ea),
        .xlate_i      (xlate_w),
        .tlb_u0_i     (tlb_u0),
        .region_map_i (u0_region_map),
        .u0_attr_o    (u0_attr_w)
    );

    afu_cause_eval u_cause (
        .user_i       (user_w),
        .xlate_i      (xlate_w),
        .zone_i       (zone),
        .wr_en_i      (tlb_wr_en),
        .u0_attr_i    (u0_attr_w),
        .u0_trap_en_i (u0_trap_en),
        .zone_elig_i  (zone_elig_w),
        .store_like_i (store_like_w),
        .cause_o      (cause_w)
    );

    assign fault_w = acc_valid && (cause_w != '0);

    always_comb begin
        state_d     = state_q;
        state_d.exc = 1'b0;
        if (fault_w) begin
            state_d.exc   = 1'b1;
            state_d.cause = cause_w;
            state_d.vec   = {vec_prefix, VEC_OFFSET};
            state_d.srr0  = acc_ea;
            state_d.srr1  = msr_in;
            state_d.msr   = msr_in;
            state_d.msr[MSR_XL_BIT] = 1'b0;
            state_d.msr[MSR_US_BIT] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign exc_taken  = state_q.exc;
    assign exc_cause  = state_q.cause;
    assign exc_vector = state_q.vec;
    assign srr0       = state_q.srr0;
    assign srr1       = state_q.srr1;
    assign msr_out    = state_q.msr;

    assert_real_mode_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !xlate_w |-> (!cause_w[CAUSE_NOACC] && !cause_w[CAUSE_RDONLY]));

    assert_noacc_user_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cause_w[CAUSE_NOACC] |-> (user_w && zone == ZONE_NOACC));

    assert_u0_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !u0_trap_en |-> !cause_w[CAUSE_U0]);

    assert_srr_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && cause_w != '0) |=> (exc_taken && srr0 == $past(acc_ea)
                                          && srr1 == $past(msr_in)));

    assert_msr_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> (!msr_out[MSR_XL_BIT] && !msr_out[MSR_US_BIT]));

    assert_cause_present_R10: assert property (@(posedge clk) disable iff (!rst_n)
        exc_taken |-> (exc_cause != '0));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (!exc_taken && $stable(srr0) && $stable(srr1)
                        && $stable(msr_out)));
endmodule

// File: tb/access_fault_unit_tb_top.sv
`timescale 1ns/1ps
module access_fault_unit_tb_top;
    localparam int XL = 4;
    localparam int US = 14;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        acc_valid;
    logic [3:0]  acc_class;
    logic [31:0] acc_ea;
    logic [31:0] msr_in;
    logic [1:0]  zone;
    logic        tlb_wr_en;
    logic        tlb_u0;
    logic [31:0] u0_region_map;
    logic        u0_trap_en;
    logic [15:0] vec_prefix;
    logic        exc_taken;
    logic [2:0]  exc_cause;
    logic [31:0] exc_vector;
    logic [31:0] srr0;
    logic [31:0] srr1;
    logic [31:0] msr_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic        m_exc;
    logic [2:0]  m_cause;
    logic [31:0] m_vec, m_srr0, m_srr1, m_msr;

    always #2 clk = ~clk;

    access_fault_unit dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_class(acc_class),
        .acc_ea(acc_ea), .msr_in(msr_in), .zone(zone), .tlb_wr_en(tlb_wr_en),
        .tlb_u0(tlb_u0), .u0_region_map(u0_region_map), .u0_trap_en(u0_trap_en),
        .vec_prefix(vec_prefix), .exc_taken(exc_taken), .exc_cause(exc_cause),
        .exc_vector(exc_vector), .srr0(srr0), .srr1(srr1), .msr_out(msr_out)
    );

    function automatic logic [2:0] ref_cause(int cls, logic [31:0] ea, logic [31:0] msr,
                                             logic [1:0] zn, bit wr, bit tu0,
                                             logic [31:0] map, bit en);
        bit user = msr[US];
        bit dr   = msr[XL];
        bit zacc = (cls >= 1 && cls <= 6);
        bit st   = user ? (cls == 2 || cls == 5)
                        : (cls == 2 || cls == 5 || cls == 7 || cls == 8);
        bit ovr  = user ? (zn == 2'd3) : (zn >= 2'd2);
        bit u0a  = dr ? tu0 : map[ea[31:27]];
        logic [2:0] c;
        c[0] = user && dr && zn == 2'd0 && zacc;
        c[1] = dr && !wr && st && !ovr;
        c[2] = en && u0a && st;
        return c;
    endfunction

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        chk(tag, "exc_taken", {31'd0, exc_taken}, {31'd0, m_exc});
        chk(tag, "exc_cause", {29'd0, exc_cause}, {29'd0, m_cause});
        chk(tag, "exc_vector", exc_vector, m_vec);
        chk(tag, "srr0", srr0, m_srr0);
        chk(tag, "srr1", srr1, m_srr1);
        chk(tag, "msr_out", msr_out, m_msr);
    endtask

    task automatic access(string tag, bit v, int cls, logic [31:0] ea, logic [31:0] msr,
                          logic [1:0] zn, bit wr, bit tu0, logic [31:0] map, bit en,
                          logic [15:0] pfx);
        logic [2:0] c;
        @(negedge clk);
        acc_valid = v; acc_class = cls[3:0]; acc_ea = ea; msr_in = msr; zone = zn;
        tlb_wr_en = wr; tlb_u0 = tu0; u0_region_map = map; u0_trap_en = en;
        vec_prefix = pfx;
        c = ref_cause(cls, ea, msr, zn, wr, tu0, map, en);
        @(posedge clk);
        #1;
        if (v && c != 3'd0) begin
            m_exc = 1'b1; m_cause = c; m_vec = {pfx, 16'h0300};
            m_srr0 = ea; m_srr1 = msr; m_msr = msr;
            m_msr[XL] = 1'b0; m_msr[US] = 1'b0;
        end else begin
            m_exc = 1'b0;
        end
        compare_all(tag);
    endtask

    localparam logic [31:0] U_V = 32'h0000_4010;
    localparam logic [31:0] P_V = 32'h0000_0010;
    localparam logic [31:0] U_R = 32'h0000_4000;
    localparam logic [31:0] P_R = 32'h0000_0000;

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; acc_valid = 0; acc_class = 0; acc_ea = 0; msr_in = 0; zone = 0;
        tlb_wr_en = 1; tlb_u0 = 0; u0_region_map = 0; u0_trap_en = 0; vec_prefix = 0;
        m_exc = 0; m_cause = 0; m_vec = 0; m_srr0 = 0; m_srr1 = 0; m_msr = 0;
        repeat (3) @(posedge clk);
        #1;
        compare_all("R12 reset");
        @(negedge clk);
        rst_n = 1'b1;

        access("R1 user load zone0", 1, 1, 32'h1000_0040, U_V | 32'h8000, 2'd0, 1, 0, 0, 0, 16'hFFF0);
        access("R1 icache inv zone0", 1, 6, 32'h2000_0000, U_V, 2'd0, 1, 0, 0, 0, 16'h0001);
        access("R1 none class zone0", 1, 0, 32'h2000_0004, U_V, 2'd0, 1, 0, 0, 0, 16'h0001);
        access("R1 priv zone0", 1, 1, 32'h2000_0008, P_V, 2'd0, 1, 0, 0, 0, 16'h0001);
        access("R1 dcache inv user zone0", 1, 7, 32'h2000_000C, U_V, 2'd0, 0, 0, 0, 0, 16'h0001);
        access("R2 user store ro", 1, 2, 32'h3000_0000, U_V, 2'd1, 0, 0, 0, 0, 16'h0002);
        access("R2 user zero ro zone2", 1, 5, 32'h3000_0010, U_V, 2'd2, 0, 0, 0, 0, 16'h0002);
        access("R2 user store zone3", 1, 2, 32'h3000_0020, U_V, 2'd3, 0, 0, 0, 0, 16'h0002);
        access("R2 user setinv ro", 1, 8, 32'h3000_0030, U_V, 2'd1, 0, 0, 0, 0, 16'h0002);
        access("R3 priv store ro", 1, 2, 32'h4000_0000, P_V, 2'd1, 0, 0, 0, 0, 16'h0003);
        access("R3 priv setinv zone0", 1, 8, 32'h4000_0010, P_V, 2'd0, 0, 0, 0, 0, 16'h0003);
        access("R3 priv store zone2", 1, 2, 32'h4000_0020, P_V, 2'd2, 0, 0, 0, 0, 16'h0003);
        access("R3 priv load ro", 1, 1, 32'h4000_0030, P_V, 2'd1, 0, 0, 0, 0, 16'h0003);
        access("R4 real user store", 1, 2, 32'h5000_0000, U_R, 2'd0, 0, 0, 0, 0, 16'h0004);
        access("R4 real priv dcinv", 1, 7, 32'h5000_0010, P_R, 2'd1, 0, 0, 0, 0, 16'h0004);
        access("R5 real region5", 1, 2, 32'h2800_0000, P_R, 2'd0, 1, 0, 32'h20, 1, 16'h0005);
        access("R5 real region4", 1, 2, 32'h27FF_FFFC, P_R, 2'd0, 1, 0, 32'h20, 1, 16'h0005);
        access("R5 real region0", 1, 5, 32'h0000_0000, U_R, 2'd0, 1, 0, 32'h1, 1, 16'h0005);
        access("R5 real region31", 1, 2, 32'hFFFF_FFF0, U_R, 2'd0, 1, 0, 32'h8000_0000, 1, 16'h0005);
        access("R5 virt tlb u0", 1, 2, 32'h6000_0000, U_V, 2'd1, 1, 1, 32'h0, 1, 16'h0005);
        access("R5 virt map ignored", 1, 2, 32'h0000_0100, U_V, 2'd1, 1, 0, 32'hFFFF_FFFF, 1, 16'h0005);
        access("R5 virt load u0", 1, 1, 32'h6000_0010, U_V, 2'd1, 1, 1, 32'h0, 1, 16'h0005);
        access("R6 trap disabled", 1, 2, 32'h0000_0200, P_R, 2'd0, 1, 1, 32'hFFFF_FFFF, 0, 16'h0006);
        access("R10 all causes", 1, 2, 32'h7000_0000, U_V, 2'd0, 0, 1, 0, 1, 16'hABCD);
        access("R10 ro and u0", 1, 7, 32'h7000_0010, P_V, 2'd1, 0, 1, 0, 1, 16'h1234);
        access("R11 valid low", 0, 2, 32'h7100_0000, U_V, 2'd0, 0, 1, 0, 1, 16'h5555);
        access("R11 valid low again", 0, 1, 32'h7100_0004, U_V, 2'd0, 0, 0, 0, 0, 16'h5555);
        access("R9 vector prefix", 1, 2, 32'h7200_0000, 32'hFFFF_FFFF, 2'd1, 0, 0, 0, 0, 16'hBEEF);
        access("R8 msr clear", 1, 1, 32'h7300_0000, 32'h5A5A_7A5A, 2'd0, 1, 0, 0, 0, 16'h0000);

        for (int i = 0; i < 400; i++) begin
            logic [31:0] m = $urandom;
            access("R7 random", ($urandom % 4) != 0, $urandom % 10, $urandom, m,
                   2'($urandom), 1'($urandom), 1'($urandom), $urandom, 1'($urandom),
                   16'($urandom));
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule